// File: doc/BRIEF.md
# Card Slot Power Mode Controller

This block is the digital control core of a removable-card slot power switch. It watches already-synchronized comparator flags for the auxiliary, 3.3 V and 1.5 V input supplies, the host's active-low shutdown and standby requests, two active-low card-detect lines and three per-rail overcurrent flags. From these it chooses one of five slot modes. For each of the three switched rails it drives a switch enable and a discharge enable, so every rail is either powered, left floating, or pulled to ground.

The mode depends on history as well as on the present inputs. A standby request that arrives while a card is already powered keeps the auxiliary rail alive. The same request made before the card shows up leaves the whole slot dark until standby is released. Losing a main supply while the card is powered drops only the main rails. A separate filter drives an open-drain style overcurrent status output. It reacts only to conditions that persist for a programmable number of millisecond ticks, both when the condition starts and when it ends.

Top module: `slot_power_ctrl`

## Requirements
- R1: While aux_ok is low, mode reads 0 (off) and every bit of rail_sw_en and rail_dis_en is 0; this takes priority over every other input.
- R2: With aux_ok high and shdn_n low, mode reads 1 (shutdown), rail_sw_en is 000 and rail_dis_en is 111, whatever the other inputs are.
- R3: A card counts as present when cp_a_n or cp_b_n is low. With aux_ok and shdn_n high and both lines high, mode reads 2 (no card), rail_sw_en is 000 and rail_dis_en is 111.
- R4: If stby_n falls while the slot is powered (mode 4), mode becomes 3 (standby): rail_sw_en is 001 (bit 0 auxiliary, bit 1 3.3 V, bit 2 1.5 V) and rail_dis_en is 000.
- R5: If stby_n is low while no card is present, a later card insertion gives mode 0 with all enables 0. This holds for as long as stby_n stays low and ends once stby_n returns high.
- R6: If main33_ok or main15_ok falls while the slot is in mode 4, mode becomes 3 with rail_sw_en 001. If a card is inserted while a main supply is already invalid, mode is 0 with all enables 0.
- R7: With all supplies valid, a card present and shdn_n and stby_n high, mode reads 4 (card active) and rail_sw_en is 111 with rail_dis_en 000.
- R8: oc_n goes low once any bit of oc_flag has been high for DEGLITCH_TICKS consecutive tick_1ms pulses (default 20). It returns high once all bits have been low for the same count.
- R9: An oc_flag change that lasts fewer than DEGLITCH_TICKS ticks leaves oc_n unchanged.
- R10: No rail has its switch and discharge enables high together. A rail changing between switched-on and discharged spends at least one cycle with both low.
- R11: mode follows its inputs with one cycle of latency, and the rail enables follow mode one cycle later, plus one more cycle when R10 forces a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond for the overcurrent filter |
| aux_ok | input | 1 | Auxiliary input supply above its undervoltage threshold |
| main33_ok | input | 1 | 3.3 V input supply above its undervoltage threshold |
| main15_ok | input | 1 | 1.5 V input supply above its undervoltage threshold |
| shdn_n | input | 1 | Active-low shutdown request |
| stby_n | input | 1 | Active-low standby request |
| cp_a_n | input | 1 | Active-low card detect, first card type |
| cp_b_n | input | 1 | Active-low card detect, second card type |
| oc_flag | input | 3 | Per-rail overcurrent flags (bit 0 aux, 1 3.3 V, 2 1.5 V) |
| rail_sw_en | output | 3 | Per-rail power switch enable |
| rail_dis_en | output | 3 | Per-rail discharge path enable |
| oc_n | output | 1 | Filtered overcurrent status, low when asserted |
| mode | output | 3 | Encoded slot mode: 0 off, 1 shutdown, 2 no card, 3 standby, 4 active |

## Verification
The hardest state to reach from the ports is the latched standby-before-card condition. Only an ordered sequence produces it: remove the card, lower standby, then insert the card. A single input pattern cannot reach it, because the same present inputs give standby mode when the card was powered first. The bench reaches both branches from the same final input vector by running the two orders one after the other. It also checks that raising standby releases the latch. Main-supply loss is covered the same way: once from an already powered slot and once by inserting a card into a slot whose main supply is already missing.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

   localparam int NUM_RAILS = 3;
   localparam int RAIL_AUX  = 0;
   localparam int RAIL_M33  = 1;
   localparam int RAIL_M15  = 2;

   typedef enum logic [2:0] {
      MODE_OFF      = 3'd0,
      MODE_SHUTDOWN = 3'd1,
      MODE_NOCARD   = 3'd2,
      MODE_STANDBY  = 3'd3,
      MODE_ACTIVE   = 3'd4
   } slot_mode_e;

   typedef enum logic [1:0] {
      RAIL_FLOAT = 2'd0,
      RAIL_ON    = 2'd1,
      RAIL_GND   = 2'd2
   } rail_cmd_e;

   // Rail command wanted for a given slot mode and rail index.
   function automatic rail_cmd_e rail_target(slot_mode_e m, int idx);
      rail_cmd_e c;
      case (m)
         MODE_SHUTDOWN, MODE_NOCARD: c = RAIL_GND;
         MODE_ACTIVE:                c = RAIL_ON;
         MODE_STANDBY:               c = (idx == RAIL_AUX) ? RAIL_ON : RAIL_FLOAT;
         default:                    c = RAIL_FLOAT;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/slot_mode_fsm.sv
module slot_mode_fsm
   import slot_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       aux_ok,
   input  logic       mains_ok,
   input  logic       shdn_n,
   input  logic       stby_n,
   input  logic       card,
   output slot_mode_e mode_q
);

   logic       early_q;
   logic       early_d;
   logic       early_now;
   logic       powered_prev;
   slot_mode_e mode_d;

   assign powered_prev = (mode_q == MODE_ACTIVE) || (mode_q == MODE_STANDBY);
   // Standby seen while the slot was not powered with a card latches fully-off.
   assign early_now    = early_q | (~stby_n & ~powered_prev);
   assign early_d      = stby_n ? 1'b0 : early_now;

   always_comb begin
      if (!aux_ok)
         mode_d = MODE_OFF;
      else if (!shdn_n)
         mode_d = MODE_SHUTDOWN;
      else if (!card)
         mode_d = MODE_NOCARD;
      else if (early_now)
         mode_d = MODE_OFF;
      else if (!stby_n)
         mode_d = MODE_STANDBY;
      else if (!mains_ok)
         mode_d = powered_prev ? MODE_STANDBY : MODE_OFF;
      else
         mode_d = MODE_ACTIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_OFF;
         early_q <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         early_q <= early_d;
      end
   end

   // R5: latched early standby keeps a powered-up slot dark
   p_early_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (aux_ok && shdn_n && card && early_q) |=> (mode_q == MODE_OFF));

   // R6: main-supply loss from the active mode keeps auxiliary only
   p_main_loss_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (aux_ok && shdn_n && card && stby_n && !mains_ok && mode_q == MODE_ACTIVE)
      |=> (mode_q == MODE_STANDBY));

endmodule

// File: rtl/rail_drive.sv
module rail_drive
   import slot_pwr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  rail_cmd_e target,
   output logic      sw_en,
   output logic      dis_en
);

   logic sw_d;
   logic dis_d;

   // Break-before-make: an opposite path must be released for one cycle first.
   always_comb begin
      sw_d  = 1'b0;
      dis_d = 1'b0;
      case (target)
         RAIL_ON:  sw_d  = ~dis_en;
         RAIL_GND: dis_d = ~sw_en;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_en  <= 1'b0;
         dis_en <= 1'b0;
      end else begin
         sw_en  <= sw_d;
         dis_en <= dis_d;
      end
   end

   // R10: switch and discharge never overlap
   p_no_overlap_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_en && dis_en));

   // R10: switch turns on only after a cycle with discharge released
   p_gap_on_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en) |-> $past(!dis_en));

   // R10: discharge turns on only after a cycle with switch released
   p_gap_dis_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dis_en) |-> $past(!sw_en));

endmodule

// File: rtl/oc_deglitch.sv
module oc_deglitch #(
   parameter int NUM_FLAGS      = 3,
   parameter int DEGLITCH_TICKS = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [NUM_FLAGS-1:0] flags,
   output logic                 oc_active
);

   localparam int CW = $clog2(DEGLITCH_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(DEGLITCH_TICKS - 1);

   if (DEGLITCH_TICKS < 2) begin : g_bad_ticks
      $error("oc_deglitch: DEGLITCH_TICKS must be at least 2");
   end
   if (NUM_FLAGS < 1) begin : g_bad_flags
      $error("oc_deglitch: NUM_FLAGS must be at least 1");
   end

   logic          raw;
   logic [CW-1:0] cnt_q;

   assign raw = |flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_active <= 1'b0;
         cnt_q     <= '0;
      end else if (raw == oc_active) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (cnt_q == LAST) begin
            oc_active <= raw;
            cnt_q     <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   // R9: the filtered status moves only on a tick
   p_move_on_tick_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (oc_active != $past(oc_active)) |-> $past(tick));

   // R8: the filtered status moves only toward the raw condition
   p_move_toward_raw_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (oc_active != $past(oc_active)) |-> (oc_active == $past(raw)));

endmodule

// File: rtl/slot_power_ctrl.sv
module slot_power_ctrl
   import slot_pwr_pkg::*;
#(
   parameter int DEGLITCH_TICKS = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_1ms,
   input  logic                 aux_ok,
   input  logic                 main33_ok,
   input  logic                 main15_ok,
   input  logic                 shdn_n,
   input  logic                 stby_n,
   input  logic                 cp_a_n,
   input  logic                 cp_b_n,
   input  logic [NUM_RAILS-1:0] oc_flag,
   output logic [NUM_RAILS-1:0] rail_sw_en,
   output logic [NUM_RAILS-1:0] rail_dis_en,
   output logic                 oc_n,
   output logic [2:0]           mode
);

   slot_mode_e mode_q;
   logic       card;
   logic       mains_ok;
   logic       oc_active;

   assign card     = ~cp_a_n | ~cp_b_n;
   assign mains_ok = main33_ok & main15_ok;

   slot_mode_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .aux_ok   (aux_ok),
      .mains_ok (mains_ok),
      .shdn_n   (shdn_n),
      .stby_n   (stby_n),
      .card     (card),
      .mode_q   (mode_q)
   );

   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      rail_cmd_e tgt;
      assign tgt = rail_target(mode_q, i);
      rail_drive u_drv (
         .clk    (clk),
         .rst_n  (rst_n),
         .target (tgt),
         .sw_en  (rail_sw_en[i]),
         .dis_en (rail_dis_en[i])
      );
   end

   oc_deglitch #(
      .NUM_FLAGS      (NUM_RAILS),
      .DEGLITCH_TICKS (DEGLITCH_TICKS)
   ) u_oc (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_1ms),
      .flags     (oc_flag),
      .oc_active (oc_active)
   );

   assign oc_n = ~oc_active;
   assign mode = mode_q;

   // R1: auxiliary loss forces the off mode next cycle
   p_aux_loss_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !aux_ok |=> (mode == 3'd0));

   // R2: shutdown dominates everything but auxiliary loss
   p_shutdown_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (aux_ok && !shdn_n) |=> (mode == 3'd1));

   // R11: rails follow a settled mode one cycle later
   p_active_rails_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4 && $past(mode) == 3'd4 && $past(mode, 2) == 3'd4)
      |-> (rail_sw_en == '1 && rail_dis_en == '0));

endmodule

// File: tb/slot_power_ctrl_test.sv
module slot_power_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1ms = 1'b0;
   logic       aux_ok = 1'b0, main33_ok = 1'b0, main15_ok = 1'b0;
   logic       shdn_n = 1'b1, stby_n = 1'b1, cp_a_n = 1'b1, cp_b_n = 1'b1;
   logic [2:0] oc_flag = 3'b000;
   logic [2:0] rail_sw_en, rail_dis_en, mode;
   logic       oc_n;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   slot_power_ctrl uut (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
      .aux_ok(aux_ok), .main33_ok(main33_ok), .main15_ok(main15_ok),
      .shdn_n(shdn_n), .stby_n(stby_n), .cp_a_n(cp_a_n), .cp_b_n(cp_b_n),
      .oc_flag(oc_flag), .rail_sw_en(rail_sw_en), .rail_dis_en(rail_dis_en),
      .oc_n(oc_n), .mode(mode)
   );

   initial begin
      forever begin
         repeat (4) @(posedge clk);
         #2 tick_1ms = 1'b1;
         @(posedge clk);
         #2 tick_1ms = 1'b0;
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_slot(input string req, input logic [2:0] sw, input logic [2:0] dis,
                           input logic [2:0] md);
      chk({req, " sw"},   {5'd0, rail_sw_en},  {5'd0, sw});
      chk({req, " dis"},  {5'd0, rail_dis_en}, {5'd0, dis});
      chk({req, " mode"}, {5'd0, mode},        {5'd0, md});
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_ticks(input int n);
      int seen = 0;
      while (seen < n) begin
         @(negedge clk);
         if (tick_1ms) seen++;
      end
   endtask

   task automatic all_good();
      @(negedge clk);
      aux_ok = 1; main33_ok = 1; main15_ok = 1;
      shdn_n = 1; stby_n = 1; cp_a_n = 0; cp_b_n = 1;
      settle();
   endtask

   task automatic t_reset();
      chk_slot("R1 reset", 3'b000, 3'b000, 3'd0);
      chk("R8 reset oc_n", {7'd0, oc_n}, 8'd1);
   endtask

   task automatic t_aux_off();
      @(negedge clk);
      aux_ok = 0; main33_ok = 1; main15_ok = 1; cp_a_n = 0; shdn_n = 0;
      settle();
      chk_slot("R1 aux low", 3'b000, 3'b000, 3'd0);
   endtask

   task automatic t_power_up();
      all_good();
      chk_slot("R7 active", 3'b111, 3'b000, 3'd4);
   endtask

   task automatic t_card_lines();
      @(negedge clk); cp_a_n = 1; cp_b_n = 0;
      settle();
      chk_slot("R3 second line only", 3'b111, 3'b000, 3'd4);
      @(negedge clk); cp_b_n = 1;
      settle();
      chk_slot("R3 no card", 3'b000, 3'b111, 3'd2);
      all_good();
   endtask

   task automatic t_shutdown();
      all_good();
      @(negedge clk); shdn_n = 0; stby_n = 0; main15_ok = 0;
      @(negedge clk);
      chk("R11 mode after one edge", {5'd0, mode}, 8'd1);
      @(negedge clk);
      chk_slot("R10 gap cycle", 3'b000, 3'b000, 3'd1);
      @(negedge clk);
      chk_slot("R2 shutdown", 3'b000, 3'b111, 3'd1);
      all_good();
      chk_slot("R10 back on after discharge", 3'b111, 3'b000, 3'd4);
   endtask

   task automatic t_standby_late();
      all_good();
      @(negedge clk); stby_n = 0;
      settle();
      chk_slot("R4 standby after card", 3'b001, 3'b000, 3'd3);
      @(negedge clk); stby_n = 1;
      settle();
      chk_slot("R4 standby released", 3'b111, 3'b000, 3'd4);
   endtask

   task automatic t_standby_early();
      all_good();
      @(negedge clk); cp_a_n = 1;
      settle();
      @(negedge clk); stby_n = 0;
      settle();
      chk_slot("R3 no card with standby", 3'b000, 3'b111, 3'd2);
      @(negedge clk); cp_a_n = 0;
      settle();
      chk_slot("R5 card after standby", 3'b000, 3'b000, 3'd0);
      repeat (10) @(negedge clk);
      chk_slot("R5 held", 3'b000, 3'b000, 3'd0);
      @(negedge clk); stby_n = 1;
      settle();
      chk_slot("R5 released", 3'b111, 3'b000, 3'd4);
   endtask

   task automatic t_main_loss();
      all_good();
      @(negedge clk); main15_ok = 0;
      settle();
      chk_slot("R6 1v5 loss", 3'b001, 3'b000, 3'd3);
      @(negedge clk); main15_ok = 1;
      settle();
      chk_slot("R6 1v5 restored", 3'b111, 3'b000, 3'd4);
      @(negedge clk); main33_ok = 0;
      settle();
      chk_slot("R6 3v3 loss", 3'b001, 3'b000, 3'd3);
      @(negedge clk); cp_a_n = 1;
      settle();
      @(negedge clk); cp_a_n = 0;
      settle();
      chk_slot("R6 card into missing main", 3'b000, 3'b000, 3'd0);
      @(negedge clk); main33_ok = 1;
      settle();
      chk_slot("R6 main returns", 3'b111, 3'b000, 3'd4);
   endtask

   task automatic t_aux_loss_active();
      all_good();
      @(negedge clk); aux_ok = 0;
      settle();
      chk_slot("R1 aux lost while active", 3'b000, 3'b000, 3'd0);
      all_good();
   endtask

   task automatic t_overcurrent();
      @(negedge clk); oc_flag = 3'b010;
      wait_ticks(10);
      @(negedge clk); oc_flag = 3'b000;
      wait_ticks(25);
      chk("R9 short glitch ignored", {7'd0, oc_n}, 8'd1);
      @(negedge clk); oc_flag = 3'b001;
      wait_ticks(18);
      chk("R8 before deglitch", {7'd0, oc_n}, 8'd1);
      wait_ticks(4);
      chk("R8 asserted", {7'd0, oc_n}, 8'd0);
      @(negedge clk); oc_flag = 3'b000;
      wait_ticks(8);
      @(negedge clk); oc_flag = 3'b100;
      wait_ticks(25);
      chk("R9 short release ignored", {7'd0, oc_n}, 8'd0);
      @(negedge clk); oc_flag = 3'b000;
      wait_ticks(18);
      chk("R8 release before deglitch", {7'd0, oc_n}, 8'd0);
      wait_ticks(4);
      chk("R8 released", {7'd0, oc_n}, 8'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_aux_off();
      t_power_up();
      t_card_lines();
      t_shutdown();
      t_standby_late();
      t_standby_early();
      t_main_loss();
      t_aux_loss_active();
      t_overcurrent();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog (all requirements) actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule